// File: doc/BRIEF.md
# DMA Scatter-Gather Address Generator

This block computes the source and destination byte addresses of one DMA channel while a block transfer runs. A start strobe loads both start addresses and the per-side settings then in force. These settings are the update direction, the transaction width, the burst length, and a segment length with a skip distance. Each accepted transaction strobe moves both addresses by one transaction. When a side has moved a whole segment, that side also skips the programmed distance, so the source can gather from strided regions and the destination can scatter into them, independently of each other.

A byte counter measures progress against a block limit. The last transaction that reaches the limit produces a one-cycle completion pulse. The addresses then freeze until the next start. Burst-position flags tell the bus side which transaction opens a burst and which closes it. The controller is a three-state machine. IDLE is the state after reset. RUN is entered from IDLE or HALT by `start`, and `start` in RUN restarts the block. HALT is entered from RUN by the final transaction.

Top module: `sg_addr_gen`

## Requirements
- R1: `start` loads `src_base`/`dst_base` into the address outputs on the next cycle, clears all counters and enters RUN from any state; a `xfer` in the same cycle as `start` is not counted.
- R2: The update mode per side is 0 = increment, 1 = decrement, 2 or 3 = hold. In hold the address never changes during the block.
- R3: The width code per side is 0..3, for 1, 2, 4 or 8 bytes. The address step of one transaction equals that width.
- R4: On the source side, a transaction whose bytes bring the segment count to `gather_len` or beyond moves the address by the step plus `gather_skip`, in the mode's direction, and clears the segment count.
- R5: The destination side does the same with `scatter_len` and `scatter_skip`, independently of the source.
- R6: A segment length of 0, or hold mode, disables skipping on that side.
- R7: Source-width bytes are counted per transaction. The transaction that brings the count to `block_limit` or beyond is the last one, and `block_done` is high for exactly the following cycle while `running` drops. A limit of 0 means 65536 bytes (2^CNT_W).
- R8: Outside RUN, `xfer` has no effect and both addresses hold.
- R9: The burst code per side selects 0 = 1, 1 = 4, 2 = 8 or 3 = 16 transactions. The `*_first` flag is high when the count of transactions modulo the burst length is 0, and the `*_last` flag is high when that count equals the length minus 1.
- R10: After reset, both addresses are 0, `running` and `block_done` are low, and each burst counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start | input | 1 | load addresses and begin a block |
| xfer | input | 1 | one transaction accepted |
| src_base | input | 32 | source start address |
| dst_base | input | 32 | destination start address |
| src_mode | input | 2 | source update mode |
| dst_mode | input | 2 | destination update mode |
| src_width | input | 2 | source width code |
| dst_width | input | 2 | destination width code |
| src_burst | input | 2 | source burst code |
| dst_burst | input | 2 | destination burst code |
| gather_len | input | 16 | source segment length in bytes |
| gather_skip | input | 16 | source skip in bytes |
| scatter_len | input | 16 | destination segment length in bytes |
| scatter_skip | input | 16 | destination skip in bytes |
| block_limit | input | 16 | block byte limit, 0 = full range |
| src_addr | output | 32 | current source address |
| dst_addr | output | 32 | current destination address |
| running | output | 1 | block in progress |
| block_done | output | 1 | one-cycle completion pulse |
| src_first | output | 1 | next source transaction opens a burst |
| src_last | output | 1 | next source transaction closes a burst |
| dst_first | output | 1 | next destination transaction opens a burst |
| dst_last | output | 1 | next destination transaction closes a burst |

## Verification
Two functions can act on the same transaction. A segment skip can coincide with the block-limit stop, and a restart can coincide with a transaction strobe. The bench provokes the first with directed settings in which the segment length divides the limit, and it judges that the final address includes the skip and that the addresses then stay frozen. It provokes the second by raising `xfer` together with `start` in random blocks, and it judges that the loaded addresses are exact and the byte count starts from zero.

// File: rtl/sg_pkg.sv
package sg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } blk_state_e;

    localparam int STEP_W  = 4;
    localparam int BLEN_W  = 5;

    function automatic logic [STEP_W-1:0] width_bytes(input logic [1:0] code);
        return STEP_W'(1) << code;
    endfunction

    function automatic logic [BLEN_W-1:0] burst_len(input logic [1:0] code);
        logic [BLEN_W-1:0] len;
        unique case (code)
            2'd0:    len = BLEN_W'(1);
            2'd1:    len = BLEN_W'(4);
            2'd2:    len = BLEN_W'(8);
            default: len = BLEN_W'(16);
        endcase
        return len;
    endfunction

    function automatic logic mode_moves(input logic [1:0] mode);
        return (mode == 2'd0) || (mode == 2'd1);
    endfunction
endpackage

// File: rtl/sg_side_addr.sv
module sg_side_addr
    import sg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] base,
    input  logic [1:0]        mode,
    input  logic [1:0]        wcode,
    input  logic [SEG_W-1:0]  seg_len,
    input  logic [SEG_W-1:0]  seg_skip,
    output logic [ADDR_W-1:0] addr
);
    localparam int ACC_W = SEG_W + 1;

    logic [ADDR_W-1:0] addr_q;
    logic [ACC_W-1:0]  seg_q;
    logic [ACC_W-1:0]  seg_nxt;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] delta;
    logic              skip_en;
    logic              crossing;

    assign step     = ADDR_W'(width_bytes(wcode));
    assign skip_en  = mode_moves(mode) && (seg_len != '0);
    assign seg_nxt  = seg_q + ACC_W'(width_bytes(wcode));
    assign crossing = skip_en && (seg_nxt >= {1'b0, seg_len});
    assign delta    = crossing ? (step + ADDR_W'(seg_skip)) : step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            seg_q  <= '0;
        end else if (load) begin
            addr_q <= base;
            seg_q  <= '0;
        end else if (advance) begin
            unique case (mode)
                2'd0:    addr_q <= addr_q + delta;
                2'd1:    addr_q <= addr_q - delta;
                default: addr_q <= addr_q;
            endcase
            if (crossing || !skip_en) seg_q <= '0;
            else                      seg_q <= seg_nxt;
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/sg_burst_cnt.sv
module sg_burst_cnt
    import sg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       advance,
    input  logic [1:0] bcode,
    output logic       first,
    output logic       last
);
    logic [BLEN_W-1:0] beat_q;
    logic [BLEN_W-1:0] len;
    logic              wrap;

    assign len   = burst_len(bcode);
    assign wrap  = (beat_q >= len - BLEN_W'(1));
    assign first = (beat_q == '0);
    assign last  = (beat_q == len - BLEN_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       beat_q <= '0;
        else if (load)    beat_q <= '0;
        else if (advance) beat_q <= wrap ? '0 : beat_q + BLEN_W'(1);
    end
endmodule

// File: rtl/sg_block_ctl.sv
module sg_block_ctl
    import sg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              xfer,
    input  logic [STEP_W-1:0] step,
    input  logic [CNT_W-1:0]  limit,
    output logic              advance,
    output logic              running,
    output logic              block_done
);
    localparam int ACC_W = CNT_W + 1;

    blk_state_e       st_q, st_d;
    logic [ACC_W-1:0] bytes_q;
    logic [ACC_W-1:0] bytes_nxt;
    logic [ACC_W-1:0] lim_full;
    logic             final_xfer;
    logic             done_q;

    assign lim_full   = (limit == '0) ? (ACC_W'(1) << CNT_W) : {1'b0, limit};
    assign running    = (st_q == ST_RUN);
    assign advance    = running && xfer && !start;
    assign bytes_nxt  = bytes_q + ACC_W'(step);
    assign final_xfer = advance && (bytes_nxt >= lim_full);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_d = ST_RUN;
            ST_RUN: begin
                if (start)           st_d = ST_RUN;
                else if (final_xfer) st_d = ST_HALT;
            end
            ST_HALT: if (start) st_d = ST_RUN;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bytes_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= final_xfer;
            if (start)        bytes_q <= '0;
            else if (advance) bytes_q <= bytes_nxt;
        end
    end

    assign block_done = done_q;
endmodule

// File: rtl/sg_addr_gen.sv
module sg_addr_gen
    import sg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEG_W  = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              xfer,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [1:0]        src_mode,
    input  logic [1:0]        dst_mode,
    input  logic [1:0]        src_width,
    input  logic [1:0]        dst_width,
    input  logic [1:0]        src_burst,
    input  logic [1:0]        dst_burst,
    input  logic [SEG_W-1:0]  gather_len,
    input  logic [SEG_W-1:0]  gather_skip,
    input  logic [SEG_W-1:0]  scatter_len,
    input  logic [SEG_W-1:0]  scatter_skip,
    input  logic [CNT_W-1:0]  block_limit,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              running,
    output logic              block_done,
    output logic              src_first,
    output logic              src_last,
    output logic              dst_first,
    output logic              dst_last
);
    localparam int SIDES = 2;

    logic              advance;
    logic [ADDR_W-1:0] base_a  [SIDES];
    logic [1:0]        mode_a  [SIDES];
    logic [1:0]        wcode_a [SIDES];
    logic [1:0]        bcode_a [SIDES];
    logic [SEG_W-1:0]  len_a   [SIDES];
    logic [SEG_W-1:0]  skip_a  [SIDES];
    logic [ADDR_W-1:0] addr_a  [SIDES];
    logic              first_a [SIDES];
    logic              last_a  [SIDES];

    assign base_a[0]  = src_base;
    assign base_a[1]  = dst_base;
    assign mode_a[0]  = src_mode;
    assign mode_a[1]  = dst_mode;
    assign wcode_a[0] = src_width;
    assign wcode_a[1] = dst_width;
    assign bcode_a[0] = src_burst;
    assign bcode_a[1] = dst_burst;
    assign len_a[0]   = gather_len;
    assign len_a[1]   = scatter_len;
    assign skip_a[0]  = gather_skip;
    assign skip_a[1]  = scatter_skip;

    sg_block_ctl #(.CNT_W(CNT_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .xfer       (xfer),
        .step       (width_bytes(src_width)),
        .limit      (block_limit),
        .advance    (advance),
        .running    (running),
        .block_done (block_done)
    );

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        sg_side_addr #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_addr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (start),
            .advance  (advance),
            .base     (base_a[s]),
            .mode     (mode_a[s]),
            .wcode    (wcode_a[s]),
            .seg_len  (len_a[s]),
            .seg_skip (skip_a[s]),
            .addr     (addr_a[s])
        );
        sg_burst_cnt u_burst (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (start),
            .advance (advance),
            .bcode   (bcode_a[s]),
            .first   (first_a[s]),
            .last    (last_a[s])
        );
    end

    assign src_addr  = addr_a[0];
    assign dst_addr  = addr_a[1];
    assign src_first = first_a[0];
    assign src_last  = last_a[0];
    assign dst_first = first_a[1];
    assign dst_last  = last_a[1];
endmodule

// File: rtl/sg_addr_gen_chk.sv
module sg_addr_gen_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              xfer,
    input logic [ADDR_W-1:0] src_base,
    input logic [ADDR_W-1:0] dst_base,
    input logic [1:0]        src_mode,
    input logic [1:0]        dst_mode,
    input logic [1:0]        src_burst,
    input logic [1:0]        dst_burst,
    input logic [ADDR_W-1:0] src_addr,
    input logic [ADDR_W-1:0] dst_addr,
    input logic              running,
    input logic              block_done,
    input logic              src_first,
    input logic              src_last,
    input logic              dst_first,
    input logic              dst_last
);
    // R1: loaded addresses appear one cycle after start
    a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (src_addr == $past(src_base)) && (dst_addr == $past(dst_base)) && running);

    // R2: hold mode keeps the source address during a transaction
    a_r2_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (running && xfer && !start && src_mode[1]) |=> $stable(src_addr));

    a_r2_dst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (running && xfer && !start && dst_mode[1]) |=> $stable(dst_addr));

    // R7: completion pulse is one cycle wide and ends the block
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        block_done |=> !block_done);

    a_r7_done_stops: assert property (@(posedge clk) disable iff (!rst_n)
        block_done |-> !running);

    // R8: outside RUN, addresses stay put unless restarted
    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start) |=> $stable(src_addr) && $stable(dst_addr));

    // R9: a burst boundary is both first and last only for single transfers
    a_r9_src_single: assert property (@(posedge clk) disable iff (!rst_n)
        (src_first && src_last) |-> (src_burst == 2'd0));

    a_r9_dst_single: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_first && dst_last) |-> (dst_burst == 2'd0));
endmodule

bind sg_addr_gen sg_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .xfer       (xfer),
    .src_base   (src_base),
    .dst_base   (dst_base),
    .src_mode   (src_mode),
    .dst_mode   (dst_mode),
    .src_burst  (src_burst),
    .dst_burst  (dst_burst),
    .src_addr   (src_addr),
    .dst_addr   (dst_addr),
    .running    (running),
    .block_done (block_done),
    .src_first  (src_first),
    .src_last   (src_last),
    .dst_first  (dst_first),
    .dst_last   (dst_last)
);

// File: tb/tb_sg_addr_gen.sv
module tb_sg_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, xfer = 1'b0;
    logic [31:0] src_base = '0, dst_base = '0;
    logic [1:0]  src_mode = '0, dst_mode = '0, src_width = '0, dst_width = '0;
    logic [1:0]  src_burst = '0, dst_burst = '0;
    logic [15:0] gather_len = '0, gather_skip = '0, scatter_len = '0, scatter_skip = '0;
    logic [15:0] block_limit = 16'd1;
    logic [31:0] src_addr, dst_addr;
    logic        running, block_done, src_first, src_last, dst_first, dst_last;

    int vectors = 0;
    int misses  = 0;
    bit finished = 0;

    // reference state
    logic [31:0] m_src = '0, m_dst = '0;
    int m_sseg = 0, m_dseg = 0, m_bytes = 0, m_sb = 0, m_db = 0;
    bit m_run = 0, m_done = 0;

    always #5 clk = ~clk;

    sg_addr_gen dut (.*);

    function automatic int f_blen(input logic [1:0] c);
        return (c == 0) ? 1 : (4 << (c - 1));
    endfunction

    function automatic logic [31:0] f_move(input logic [31:0] a, input logic [1:0] mode,
            input logic [1:0] wc, input int len, input int skip, inout int seg);
        int st;
        int d;
        st = 1 << wc;
        d  = st;
        if (mode >= 2) begin seg = 0; return a; end
        if (len == 0) seg = 0;
        else begin
            seg += st;
            if (seg >= len) begin seg = 0; d = st + skip; end
        end
        return (mode == 0) ? a + 32'(d) : a - 32'(d);
    endfunction

    task automatic chk(input string tag, input string nm, input longint act, input longint exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, nm, act, exp, $time);
        end
    endtask

    // apply current inputs for one clock, advance the model, compare after the edge
    task automatic tick();
        bit adv;
        int lim;
        adv = m_run && xfer && !start;
        lim = (block_limit == 0) ? 65536 : int'(block_limit);
        m_done = 0;
        if (start) begin
            m_src = src_base; m_dst = dst_base;
            m_sseg = 0; m_dseg = 0; m_bytes = 0; m_sb = 0; m_db = 0; m_run = 1;
        end else if (adv) begin
            m_src = f_move(m_src, src_mode, src_width, int'(gather_len), int'(gather_skip), m_sseg);
            m_dst = f_move(m_dst, dst_mode, dst_width, int'(scatter_len), int'(scatter_skip), m_dseg);
            m_sb = (m_sb + 1) % f_blen(src_burst);
            m_db = (m_db + 1) % f_blen(dst_burst);
            m_bytes += (1 << src_width);
            if (m_bytes >= lim) begin m_run = 0; m_done = 1; end
        end
        @(negedge clk);
        chk("R4", "src_addr", src_addr, m_src);
        chk("R5", "dst_addr", dst_addr, m_dst);
        chk("R7", "block_done", block_done, m_done);
        chk("R8", "running", running, m_run);
        chk("R9", "src_first", src_first, m_sb == 0);
        chk("R9", "src_last", src_last, m_sb == f_blen(src_burst) - 1);
        chk("R9", "dst_first", dst_first, m_db == 0);
        chk("R9", "dst_last", dst_last, m_db == f_blen(dst_burst) - 1);
    endtask

    task automatic begin_block(input bit with_xfer);
        start = 1'b1; xfer = with_xfer;
        tick();
        start = 1'b0; xfer = 1'b0;
    endtask

    task automatic run_xfers(input int n);
        xfer = 1'b1;
        repeat (n) tick();
        xfer = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            misses++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "src_addr", src_addr, 0);
        chk("R10", "dst_addr", dst_addr, 0);
        chk("R10", "running", running, 0);
        chk("R10", "block_done", block_done, 0);
        chk("R10", "src_first", src_first, 1);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: xfer before any start does nothing
        run_xfers(3);
        chk("R8", "idle src_addr", src_addr, 0);

        // R1: start with simultaneous xfer, bases exact
        src_base = 32'h1000; dst_base = 32'h8000; block_limit = 16'd64;
        begin_block(1'b1);
        chk("R1", "load src", src_addr, 32'h1000);
        chk("R1", "load dst", dst_addr, 32'h8000);

        // R4/R5/R3/R2: 4-byte source gather 8/16, 1-byte dest decrement scatter 2/3
        src_mode = 0; src_width = 2; gather_len = 8; gather_skip = 16;
        dst_mode = 1; dst_width = 0; scatter_len = 2; scatter_skip = 3;
        begin_block(1'b0);
        run_xfers(4);
        chk("R4", "gather after 4", src_addr, 32'h1000 + 48);
        chk("R5", "scatter after 4", dst_addr, 32'h8000 - 10);

        // R6/R2/R3: length 0 disables skip; hold ignores a set length
        src_mode = 0; src_width = 1; gather_len = 0; gather_skip = 100;
        dst_mode = 2; dst_width = 3; scatter_len = 8; scatter_skip = 50;
        begin_block(1'b0);
        run_xfers(10);
        chk("R6", "no gather skip", src_addr, 32'h1000 + 20);
        chk("R6", "hold ignores scatter", dst_addr, 32'h8000);

        // R2 decrement plain, R3 8-byte step
        dst_mode = 1; dst_width = 3; scatter_len = 0;
        begin_block(1'b0);
        run_xfers(5);
        chk("R2", "dec dst", dst_addr, 32'h8000 - 40);

        // R7 with a skip on the final transaction, then R8 freeze
        src_mode = 0; src_width = 2; gather_len = 16; gather_skip = 32; block_limit = 16'd32;
        dst_mode = 0; dst_width = 2; scatter_len = 32; scatter_skip = 4;
        begin_block(1'b0);
        run_xfers(8);
        chk("R7", "done on final", block_done, 1);
        chk("R7", "final src incl skip", src_addr, 32'h1000 + 32 + 64);
        chk("R7", "final dst incl skip", dst_addr, 32'h8000 + 36);
        run_xfers(4);
        chk("R8", "frozen src", src_addr, 32'h1000 + 96);
        chk("R7", "pulse one cycle", block_done, 0);

        // R9: 4-beat source burst, single-transfer destination
        src_burst = 1; dst_burst = 0; block_limit = 16'd200;
        begin_block(1'b0);
        run_xfers(3);
        chk("R9", "src_last at beat 3", src_last, 1);
        chk("R9", "dst single", dst_first && dst_last, 1);

        // R7: limit 0 means 65536 bytes, 8-byte source steps
        src_width = 3; gather_len = 0; block_limit = 16'd0; src_burst = 3;
        begin_block(1'b0);
        n = 0;
        xfer = 1'b1;
        while (!block_done && n < 9000) begin tick(); n++; end
        xfer = 1'b0;
        chk("R7", "full-range xfer count", n, 8192);

        // random blocks
        for (int b = 0; b < 60; b++) begin
            src_base     = $urandom; dst_base = $urandom;
            src_mode     = 2'($urandom); dst_mode = 2'($urandom);
            src_width    = 2'($urandom); dst_width = 2'($urandom);
            src_burst    = 2'($urandom); dst_burst = 2'($urandom);
            gather_len   = 16'($urandom_range(0, 40));
            gather_skip  = 16'($urandom_range(0, 300));
            scatter_len  = 16'($urandom_range(0, 40));
            scatter_skip = 16'($urandom_range(0, 300));
            block_limit  = 16'($urandom_range(1, 400));
            begin_block(1'($urandom));
            for (int c = 0; c < 300 && m_run; c++) begin
                xfer = ($urandom_range(0, 9) < 7);
                tick();
            end
            xfer = 1'b1;
            repeat (2) tick();
            xfer = 1'b0;
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule